// File: doc/BRIEF.md
# Buffered Edge/Center PWM Channel Timer

This block is one 8-bit pulse-width-modulation channel. A counter advances on every clock cycle in which the `tick` clock-enable is high. The counter's value is compared against an active duty value to drive one registered output pin. Software reaches the channel through a small write/read register port. Through it, software sets the enable, polarity and alignment bits, writes new period and duty values, and reads or clears the counter.

Period and duty writes go into holding buffers. The counter and the comparator use separate active copies, which are refreshed only at a reload point. For this reason, a write in the middle of a cycle never produces a runt pulse or a stretched pulse.

There are two waveform modes:
- **Edge mode:** the counter runs upward and wraps.
- **Center mode:** the counter climbs to the period value and then falls back, so the pulse sits symmetrically within a cycle of twice the period.

The first cycle after the channel is enabled may be shorter or longer than the steady-state cycle.

Top module: `pwm_chan_timer`

## Requirements
- R1: After reset, the control register reads 0, the period and duty buffers each read 0xFF, the counter reads 0, and `pwm_out` is 1 (the idle level for polarity 0).
- R2: Register map (2-bit address):
  - Address 0 is control. Bit 0 is enable, bit 1 is polarity and bit 2 is center mode.
  - Address 1 is the period buffer.
  - Address 2 is the duty buffer.
  - Address 3 is the counter.
  - Read data shows the addressed register one clock after the address is presented.
- R3: Period and duty writes land in buffers. The active copies load from the buffers only at these reload points:
  - the edge-mode wrap;
  - the center-mode return to 0;
  - enabling the channel;
  - any tick while the active period is 0.
- R4: In edge mode with period P > 0, the counter steps 0, 1, …, P−1 and then wraps to 0. The output is at its active level for D of every P ticks, where D is the duty value and 0 < D < P.
- R5: In center mode with period P > 0, the counter steps up from 0 to P and then down to 1 before it returns to 0, giving a cycle of 2P ticks. The output is active for 2D of those ticks.
- R6: With polarity 1 the active level is high and the idle level is low. With polarity 0 both levels are inverted. Each cycle starts at the active level.
- R7: If D ≥ P, the output stays at the active level for the whole cycle. If D = 0, it stays at the idle level.
- R8: While the active period is 0, the counter stays at 0.
- R9: A write to the counter address clears the counter to 0 and restarts the upward count. When the channel is enabled, `pwm_out` shows the active level on the cycle after the write.
- R10: The counter changes only on cycles where `tick` is 1, except for a clear caused by a counter write or by enabling the channel.
- R11: While the channel is disabled, the counter holds its value, and `pwm_out` is at the idle level from one cycle after the enable bit reads 0.
- R12: Writing enable from 0 to 1 clears the counter to 0 and loads the active period and duty from the buffers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Registered read data |
| tick | input | 1 | Counter clock-enable |
| pwm_out | output | 1 | Registered PWM output |

## Verification
On every cycle, the assertions check the following:
- the idle level while the channel is disabled and while the duty is zero;
- the active level after a counter write;
- that the counter is cleared by writes and frozen without ticks;
- that the counter is pinned at 0 under a zero period;
- that the active period and duty move only at a reload.

Only the bench scenarios can show the rest:
- the duty ratio of whole edge and center cycles, the cycle length, and the polarity inversion;
- the cases where the duty is at or beyond the period;
- the exact point at which a buffered period takes effect.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_PER  = 2'd1,
    ADDR_DTY  = 2'd2,
    ADDR_CNT  = 2'd3
  } reg_addr_e;

  // packed so that bit0 = enable, bit1 = polarity, bit2 = center mode
  typedef struct packed {
    logic center;
    logic pol;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_chan_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [CW-1:0]     wdata,
  input  logic [CW-1:0]     cnt,
  output logic [CW-1:0]     rdata,
  output ctrl_t             ctrl,
  output logic [CW-1:0]     per_buf,
  output logic [CW-1:0]     dty_buf,
  output logic              cnt_wr,
  output logic              en_rise
);
  localparam logic [CW-1:0] BUF_RST = {CW{1'b1}};

  logic wr_ctrl, wr_per, wr_dty;

  always_comb begin
    wr_ctrl = we && (addr == ADDR_CTRL);
    wr_per  = we && (addr == ADDR_PER);
    wr_dty  = we && (addr == ADDR_DTY);
    cnt_wr  = we && (addr == ADDR_CNT);
    en_rise = wr_ctrl && wdata[0] && !ctrl.en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      per_buf <= BUF_RST;
      dty_buf <= BUF_RST;
    end else begin
      if (wr_ctrl) ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_per)  per_buf <= wdata;
      if (wr_dty)  dty_buf <= wdata;
    end
  end

  // registered readback, one cycle after the address
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADDR_CTRL: rdata <= {{(CW-CTRL_W){1'b0}}, ctrl};
        ADDR_PER:  rdata <= per_buf;
        ADDR_DTY:  rdata <= dty_buf;
        default:   rdata <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          center,
  input  logic          tick,
  input  logic          clr,
  input  logic          force_load,
  input  logic [CW-1:0] per_buf,
  input  logic [CW-1:0] dty_buf,
  output logic [CW-1:0] cnt,
  output logic          dn,
  output logic [CW-1:0] per_act,
  output logic [CW-1:0] dty_act,
  output logic          reload
);
  localparam logic [CW-1:0] ACT_RST = {CW{1'b1}};
  localparam logic [CW:0]   ONE_W   = {{CW{1'b0}}, 1'b1};

  logic [CW:0]   cnt_inc;
  logic          at_top;
  logic [CW-1:0] cnt_n;
  logic          dn_n;

  assign cnt_inc = {1'b0, cnt} + ONE_W;
  assign at_top  = cnt_inc >= {1'b0, per_act};

  always_comb begin
    cnt_n  = cnt;
    dn_n   = dn;
    reload = 1'b0;
    if (clr) begin
      cnt_n  = '0;
      dn_n   = 1'b0;
      reload = force_load;
    end else if (en && tick) begin
      if (per_act == '0) begin
        cnt_n  = '0;
        dn_n   = 1'b0;
        reload = 1'b1;
      end else if (!center) begin
        dn_n = 1'b0;
        if (at_top) begin
          cnt_n  = '0;
          reload = 1'b1;
        end else begin
          cnt_n = cnt_inc[CW-1:0];
        end
      end else if (!dn) begin
        cnt_n = cnt_inc[CW-1:0];
        if (at_top) dn_n = 1'b1;
      end else begin
        if (cnt <= {{(CW-1){1'b0}}, 1'b1}) begin
          cnt_n  = '0;
          dn_n   = 1'b0;
          reload = 1'b1;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      dn      <= 1'b0;
      per_act <= ACT_RST;
      dty_act <= ACT_RST;
    end else begin
      cnt <= cnt_n;
      dn  <= dn_n;
      if (reload) begin
        per_act <= per_buf;
        dty_act <= dty_buf;
      end
    end
  end
endmodule

// File: rtl/pwm_outcmp.sv
module pwm_outcmp #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          pol,
  input  logic          cnt_wr,
  input  logic          dn,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] per_act,
  input  logic [CW-1:0] dty_act,
  output logic          pwm_out
);
  logic below;
  logic active;

  // falling half counts the duty value itself so both halves hold D states
  assign below  = dn ? (cnt <= dty_act) : (cnt < dty_act);
  assign active = (dty_act != '0) && ((dty_act >= per_act) || below);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b1;  // idle level of polarity 0
    end else if (!en) begin
      pwm_out <= !pol;
    end else if (cnt_wr) begin
      pwm_out <= pol;
    end else begin
      pwm_out <= active ~^ pol;
    end
  end
endmodule

// File: rtl/pwm_chan_timer.sv
module pwm_chan_timer
  import pwm_chan_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [CW-1:0]     reg_wdata,
  output logic [CW-1:0]     reg_rdata,
  input  logic              tick,
  output logic              pwm_out
);
  ctrl_t         ctrl_q;
  logic          en_q, pol_q, center_q;
  logic [CW-1:0] per_buf, dty_buf, per_act, dty_act, cnt;
  logic          cnt_wr, en_rise, ctr_clr, dn, reload;

  assign en_q     = ctrl_q.en;
  assign pol_q    = ctrl_q.pol;
  assign center_q = ctrl_q.center;
  assign ctr_clr  = cnt_wr || en_rise;

  pwm_regs #(.CW(CW)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cnt(cnt), .rdata(reg_rdata), .ctrl(ctrl_q), .per_buf(per_buf),
    .dty_buf(dty_buf), .cnt_wr(cnt_wr), .en_rise(en_rise)
  );

  pwm_counter #(.CW(CW)) ctr_i (
    .clk(clk), .rst(rst), .en(en_q), .center(center_q), .tick(tick),
    .clr(ctr_clr), .force_load(en_rise), .per_buf(per_buf), .dty_buf(dty_buf),
    .cnt(cnt), .dn(dn), .per_act(per_act), .dty_act(dty_act), .reload(reload)
  );

  pwm_outcmp #(.CW(CW)) cmp_i (
    .clk(clk), .rst(rst), .en(en_q), .pol(pol_q), .cnt_wr(cnt_wr), .dn(dn),
    .cnt(cnt), .per_act(per_act), .dty_act(dty_act), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_chan_timer_chk.sv
module pwm_chan_timer_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          pol,
  input logic          tick,
  input logic          ctr_clr,
  input logic          cnt_wr,
  input logic          reload,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] per_act,
  input logic [CW-1:0] dty_act,
  input logic          pwm_out
);
  a_r11_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pwm_out == !$past(pol)));

  a_r9_write_active_level: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && en) |=> (pwm_out == $past(pol)));

  a_r9_write_clears: assert property (@(posedge clk) disable iff (rst)
    ctr_clr |=> (cnt == '0));

  a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ctr_clr) |=> $stable(cnt));

  a_r3_buffers_hold: assert property (@(posedge clk) disable iff (rst)
    !reload |=> ($stable(per_act) && $stable(dty_act)));

  a_r8_zero_period_hold: assert property (@(posedge clk) disable iff (rst)
    (en && per_act == '0) |=> (cnt == '0));

  a_r7_zero_duty_idle: assert property (@(posedge clk) disable iff (rst)
    (en && dty_act == '0 && !cnt_wr) |=> (pwm_out == !$past(pol)));
endmodule

bind pwm_chan_timer pwm_chan_timer_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst(rst), .en(en_q), .pol(pol_q), .tick(tick),
  .ctr_clr(ctr_clr), .cnt_wr(cnt_wr), .reload(reload), .cnt(cnt),
  .per_act(per_act), .dty_act(dty_act), .pwm_out(pwm_out)
);

// File: tb/pwm_chan_timer_tb_top.sv
module pwm_chan_timer_tb_top;
  localparam int CW = 8;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [CW-1:0] wdata = '0;
  logic          tick = 1'b0;
  logic [CW-1:0] rdata;
  logic          pwm_out;
  int            checks = 0;
  int            errors = 0;

  always #10 clk = ~clk;

  pwm_chan_timer #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .tick(tick), .pwm_out(pwm_out)
  );

  // {center, pol, period, duty, active count over 4 cycles, active rises}
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'd10,  8'd3,   16'd12,  6'd4},  // R4 R6 edge, pol 1
    {1'b0, 1'b0, 8'd10,  8'd7,   16'd28,  6'd4},  // R4 R6 edge, pol 0
    {1'b1, 1'b1, 8'd6,   8'd2,   16'd16,  6'd4},  // R5 center, pol 1
    {1'b1, 1'b0, 8'd5,   8'd4,   16'd32,  6'd4},  // R5 R6 center, pol 0
    {1'b0, 1'b1, 8'd8,   8'd8,   16'd32,  6'd0},  // R7 duty = period
    {1'b0, 1'b1, 8'd8,   8'd0,   16'd0,   6'd0},  // R7 duty 0
    {1'b1, 1'b1, 8'd4,   8'd9,   16'd32,  6'd0},  // R7 center duty > period
    {1'b0, 1'b1, 8'd1,   8'd1,   16'd4,   6'd0},  // R4 R7 period 1
    {1'b1, 1'b1, 8'd1,   8'd1,   16'd8,   6'd0},  // R5 R7 period 1 center
    {1'b0, 1'b1, 8'd255, 8'd100, 16'd400, 6'd4}   // R4 full range
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = int'(rdata);
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R2 readback
    check("R1 idle output", int'(pwm_out), 1);
    rd(2'd0, v); check("R1 R2 ctrl reset", v, 0);
    rd(2'd1, v); check("R1 R2 period reset", v, 255);
    rd(2'd2, v); check("R1 R2 duty reset", v, 255);
    rd(2'd3, v); check("R1 R2 counter reset", v, 0);

    // waveform vectors, tick held high
    for (int i = 0; i < NV; i++) begin
      logic c, p;
      int per, len, win, act, rises;
      logic prev, cur;
      c = VEC[i][39]; p = VEC[i][38];
      per = int'(VEC[i][37:30]);
      len = c ? 2 * per : per;
      win = 4 * len;
      wr(2'd0, 8'd0);
      wr(2'd1, VEC[i][37:30]);
      wr(2'd2, VEC[i][29:22]);
      tick = 1'b1;
      wr(2'd0, {5'd0, c, p, 1'b1});
      repeat (3 * len + 4) @(negedge clk);
      prev = pwm_out; act = 0; rises = 0;
      for (int k = 0; k < win; k++) begin
        @(negedge clk);
        cur = pwm_out;
        if (cur == p) act++;
        if (cur == p && prev != p) rises++;
        prev = cur;
      end
      check($sformatf("R4 R5 R6 R7 vec %0d active", i), act, int'(VEC[i][21:6]));
      check($sformatf("R4 R5 R6 R7 vec %0d rises", i), rises, int'(VEC[i][5:0]));
      tick = 1'b0;
    end

    // R3 R12: buffered period takes effect at the wrap
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd10);
    wr(2'd2, 8'd3);
    wr(2'd0, 8'd3);  // enable, pol 1, edge mode
    rd(2'd3, v); check("R12 counter cleared on enable", v, 0);
    pulse(5);
    wr(2'd1, 8'd20);
    pulse(4);
    rd(2'd3, v); check("R3 old period still active", v, 9);
    pulse(1);
    rd(2'd3, v); check("R3 wrap at old period", v, 0);
    pulse(15);
    rd(2'd3, v); check("R3 new period after reload", v, 15);
    rd(2'd1, v); check("R2 period buffer readback", v, 20);

    // R10 tick gating
    repeat (5) @(negedge clk);
    rd(2'd3, v); check("R10 counter frozen without tick", v, 15);

    // R9 counter write forces active level
    wr(2'd2, 8'd0);
    pulse(5);  // wrap at 20 loads duty 0
    rd(2'd3, v); check("R4 counter after wrap", v, 0);
    check("R7 duty 0 idle", int'(pwm_out), 0);
    pulse(7);
    wr(2'd3, 8'd55);
    check("R9 active level after counter write", int'(pwm_out), 1);
    @(negedge clk);
    check("R7 back to idle after write", int'(pwm_out), 0);
    rd(2'd3, v); check("R9 counter cleared by write", v, 0);

    // R5 center counting sequence
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd3);
    wr(2'd0, 8'd7);
    pulse(3);
    rd(2'd3, v); check("R5 center peak", v, 3);
    pulse(1);
    rd(2'd3, v); check("R5 center falling", v, 2);
    pulse(2);
    rd(2'd3, v); check("R5 center back to 0", v, 0);

    // R8 zero period
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'd3);
    wr(2'd0, 8'd3);
    pulse(9);
    rd(2'd3, v); check("R8 counter held at 0", v, 0);
    wr(2'd1, 8'd6);
    pulse(1);
    pulse(3);
    rd(2'd3, v); check("R3 R8 reload leaves zero period", v, 3);

    // R11 disabled: idle level and frozen counter
    wr(2'd2, 8'd9);  // loads at next wrap: always active
    pulse(6);
    check("R7 duty above period active", int'(pwm_out), 1);
    tick = 1'b1;
    wr(2'd0, 8'd2);  // disable, pol 1
    @(negedge clk);
    check("R11 idle when disabled", int'(pwm_out), 0);
    rd(2'd3, v);
    repeat (4) @(negedge clk);
    rd(2'd3, v2);
    check("R11 counter holds when disabled", v2, v);
    tick = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule